// File: doc/BRIEF.md
# Flyback Switch Cycle Timer

This block produces the gate pulse for the power switch of a flyback capacitor charger. It runs from a fixed clock. While the charge enable input is high it repeats on/off cycles. An on phase ends when the peak current comparator flags, or when a maximum on-time count runs out. An off phase ends when the off-time count runs out, or, once the block is in fast-charging mode, when an accepted end-of-conduction detect arrives.

Every off phase opens with a minimum-width window, and the short-window select input picks its length. During that window the end-of-conduction detect and the output-target comparator are both ignored. A charge starts in timer mode, a soft start in which every off phase lasts the full timeout. The block moves to fast-charging mode after a run of consecutive off phases that each saw an accepted detect. A target flag accepted inside an off phase ends the charge: the block sends a one-cycle done pulse and then keeps the switch off until charge enable drops.

All durations are cycle counts held in parameters. With the default 100 MHz clock they give an 18 µs cap on each phase and minimum off widths of 200 ns (short select) and 400 ns (long select).

Top module: `flyback_pulse_timer`

## Requirements
- R1: After reset, gate_on, target_reached and fast_mode are 0; when charge_en is high in the idle state, gate_on goes high one cycle later.
- R2: When ilim_flag is high during an on phase, gate_on is low one cycle later.
- R3: An on phase lasts at most ON_MAX cycles; without a current-limit flag gate_on stays high for exactly ON_MAX cycles.
- R4: An off phase lasts at most OFF_MAX cycles; gate_on then goes high again.
- R5: The minimum off window is MINW_SHORT cycles when short_window is 1 and MINW_LONG cycles when it is 0; a detect or target flag seen in off-phase cycle index c (0 = first low cycle) is accepted only if c >= window - 1.
- R6: In timer mode (fast_mode = 0) every off phase lasts exactly OFF_MAX cycles, even when an accepted detect arrives.
- R7: fast_mode rises, together with the rising edge of gate_on, at the end of the FAST_RUN-th consecutive off phase that contained an accepted detect; an off phase without an accepted detect resets the run.
- R8: In fast mode, an accepted detect ends the off phase, and gate_on is high on the next cycle, so the gate stays low for exactly j cycles when the detect arrives on the j-th low cycle.
- R9: target_flag is ignored during on phases and inside the minimum window. An accepted target flag gives a target_reached pulse of exactly one cycle, beginning one cycle later, and takes priority over a detect in the same cycle; after that, gate_on stays low while charge_enable remains high.
- R10: When charge_en is low, gate_on and fast_mode are 0 one cycle later; raising it again restarts switching in timer mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| charge_en | input | 1 | Charge enable; low forces idle |
| ilim_flag | input | 1 | Peak current limit comparator tripped |
| cond_end_flag | input | 1 | Secondary conduction ended (valley / slope detect) |
| target_flag | input | 1 | Output target comparator tripped |
| short_window | input | 1 | 1 selects the short minimum off window, 0 the long one |
| gate_on | output | 1 | Power switch gate drive |
| target_reached | output | 1 | One-cycle pulse when the charge completes |
| fast_mode | output | 1 | 1 in fast-charging mode, 0 in timer mode |

## Verification
gate_on and fast_mode come straight from registers, so every effect of an input appears one clock after the edge that samples it. The bench drives inputs at falling edges and samples at the next falling edge. It measures high and low run lengths in sampled cycles and compares them with values computed from the parameters. For example, a detect driven on the j-th low sample gives a low run of j when j reaches the window and OFF_MAX when it does not. A trip on the k-th high sample gives a high run of k. target_reached is checked on the sample that follows the accepted flag and again one sample after that.

// File: rtl/fbt_pkg.sv
package fbt_pkg;
  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_ON   = 2'd1,
    PH_OFF  = 2'd2,
    PH_HOLD = 2'd3
  } phase_e;
endpackage

// File: rtl/fbt_rst_sync.sv
module fbt_rst_sync (
  input  logic clk,
  input  logic rst_n_in,
  output logic rst_n_out
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n_in) begin
    if (!rst_n_in) sync_q <= 2'b00;
    else           sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_n_out = sync_q[1];
endmodule

// File: rtl/fbt_phase_counter.sv
module fbt_phase_counter #(
  parameter int W = 11
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         en,
  output logic [W-1:0] cnt
);
  localparam logic [W-1:0] TOP = {W{1'b1}};

  logic [W-1:0] cnt_q, cnt_d;
  logic         cnt_ce;

  always_comb begin
    cnt_ce = clr | en;
    if (clr)               cnt_d = '0;
    else if (cnt_q != TOP) cnt_d = cnt_q + 1'b1;
    else                   cnt_d = cnt_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_ce) cnt_q <= cnt_d;
  end

  assign cnt = cnt_q;
endmodule

// File: rtl/fbt_min_window.sv
module fbt_min_window #(
  parameter int W          = 11,
  parameter int MINW_SHORT = 20,
  parameter int MINW_LONG  = 40
) (
  input  logic [W-1:0] cnt,
  input  logic         short_sel,
  output logic         open_o
);
  localparam logic [W-1:0] TH_SHORT = W'(MINW_SHORT - 1);
  localparam logic [W-1:0] TH_LONG  = W'(MINW_LONG - 1);

  generate
    if (MINW_SHORT == MINW_LONG) begin : g_single
      logic unused_sel;
      assign unused_sel = short_sel;
      assign open_o     = (cnt >= TH_SHORT);
    end else begin : g_dual
      logic [W-1:0] th;
      assign th     = short_sel ? TH_SHORT : TH_LONG;
      assign open_o = (cnt >= th);
    end
  endgenerate
endmodule

// File: rtl/fbt_mode_tracker.sv
module fbt_mode_tracker #(
  parameter int FAST_RUN = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clear,
  input  logic mark,
  input  logic close,
  output logic fast
);
  localparam int SW = $clog2(FAST_RUN + 1);
  localparam logic [SW-1:0] RUN_MAX  = SW'(FAST_RUN);
  localparam logic [SW-1:0] RUN_LAST = SW'(FAST_RUN - 1);

  logic          seen_q, seen_d;
  logic [SW-1:0] run_q, run_d;
  logic          fast_q, fast_d;
  logic          hit;

  always_comb begin
    hit    = seen_q | mark;
    seen_d = seen_q;
    run_d  = run_q;
    fast_d = fast_q;
    if (clear) begin
      seen_d = 1'b0;
      run_d  = '0;
      fast_d = 1'b0;
    end else if (close) begin
      seen_d = 1'b0;
      if (hit) begin
        if (run_q != RUN_MAX) run_d = run_q + 1'b1;
        if (run_q >= RUN_LAST) fast_d = 1'b1;
      end else begin
        run_d = '0;
      end
    end else if (mark) begin
      seen_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seen_q <= 1'b0;
      run_q  <= '0;
      fast_q <= 1'b0;
    end else begin
      seen_q <= seen_d;
      run_q  <= run_d;
      fast_q <= fast_d;
    end
  end

  assign fast = fast_q;
endmodule

// File: rtl/flyback_pulse_timer.sv
module flyback_pulse_timer
  import fbt_pkg::*;
#(
  parameter int ON_MAX     = 1800,
  parameter int OFF_MAX    = 1800,
  parameter int MINW_SHORT = 20,
  parameter int MINW_LONG  = 40,
  parameter int FAST_RUN   = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic charge_en,
  input  logic ilim_flag,
  input  logic cond_end_flag,
  input  logic target_flag,
  input  logic short_window,
  output logic gate_on,
  output logic target_reached,
  output logic fast_mode
);
  localparam int CNT_MAX = (ON_MAX > OFF_MAX) ? ON_MAX : OFF_MAX;
  localparam int CW      = $clog2(CNT_MAX + 1);
  localparam logic [CW-1:0] ON_LAST  = CW'(ON_MAX - 1);
  localparam logic [CW-1:0] OFF_LAST = CW'(OFF_MAX - 1);

  logic          rst_n_s;
  phase_e        state_q, state_d;
  logic          done_q, done_d;
  logic [CW-1:0] cnt;
  logic          cnt_clr, cnt_en;
  logic          win_open;
  logic          mark, close;
  logic          fast;

  fbt_rst_sync u_rst (
    .clk       (clk),
    .rst_n_in  (rst_n),
    .rst_n_out (rst_n_s)
  );

  fbt_phase_counter #(.W(CW)) u_cnt (
    .clk   (clk),
    .rst_n (rst_n_s),
    .clr   (cnt_clr),
    .en    (cnt_en),
    .cnt   (cnt)
  );

  fbt_min_window #(
    .W          (CW),
    .MINW_SHORT (MINW_SHORT),
    .MINW_LONG  (MINW_LONG)
  ) u_win (
    .cnt       (cnt),
    .short_sel (short_window),
    .open_o    (win_open)
  );

  fbt_mode_tracker #(.FAST_RUN(FAST_RUN)) u_mode (
    .clk   (clk),
    .rst_n (rst_n_s),
    .clear (~charge_en),
    .mark  (mark),
    .close (close),
    .fast  (fast)
  );

  always_comb begin
    state_d = state_q;
    done_d  = 1'b0;
    cnt_clr = 1'b0;
    cnt_en  = 1'b0;
    mark    = 1'b0;
    close   = 1'b0;
    if (!charge_en) begin
      state_d = PH_IDLE;
      cnt_clr = 1'b1;
    end else begin
      case (state_q)
        PH_IDLE: begin
          state_d = PH_ON;
          cnt_clr = 1'b1;
        end
        PH_ON: begin
          if (ilim_flag || cnt == ON_LAST) begin
            state_d = PH_OFF;
            cnt_clr = 1'b1;
          end else begin
            cnt_en = 1'b1;
          end
        end
        PH_OFF: begin
          if (win_open && target_flag) begin
            state_d = PH_HOLD;
            done_d  = 1'b1;
            cnt_clr = 1'b1;
          end else begin
            mark = win_open & cond_end_flag;
            if (cnt == OFF_LAST || (fast && mark)) begin
              state_d = PH_ON;
              cnt_clr = 1'b1;
              close   = 1'b1;
            end else begin
              cnt_en = 1'b1;
            end
          end
        end
        default: begin
          state_d = PH_HOLD;
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      state_q <= PH_IDLE;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      done_q  <= done_d;
    end
  end

  assign gate_on        = (state_q == PH_ON);
  assign target_reached = done_q;
  assign fast_mode      = fast;
endmodule

// File: rtl/fbt_checker.sv
module fbt_checker #(
  parameter int ON_MAX = 1800
) (
  input logic clk,
  input logic rst_n,
  input logic charge_en,
  input logic ilim_flag,
  input logic gate_on,
  input logic target_reached,
  input logic fast_mode
);
  localparam int HW = $clog2(ON_MAX + 2);
  localparam logic [HW-1:0] HI_TOP = {HW{1'b1}};

  logic [HW-1:0] hi_cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                        hi_cnt_q <= '0;
    else if (!gate_on)                 hi_cnt_q <= '0;
    else if (hi_cnt_q != HI_TOP)       hi_cnt_q <= hi_cnt_q + 1'b1;
  end

  // R2
  ilim_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (gate_on && ilim_flag && charge_en) |=> !gate_on);

  // R3
  on_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    gate_on |-> (hi_cnt_q < HW'(ON_MAX)));

  // R10
  disable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !charge_en |=> (!gate_on && !fast_mode));

  // R9
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    target_reached |=> !target_reached);

  // R9
  done_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    target_reached |-> !gate_on);

  // R7
  fast_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fast_mode) |-> $rose(gate_on));
endmodule

bind flyback_pulse_timer fbt_checker #(.ON_MAX(ON_MAX)) u_fbt_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .charge_en      (charge_en),
  .ilim_flag      (ilim_flag),
  .gate_on        (gate_on),
  .target_reached (target_reached),
  .fast_mode      (fast_mode)
);

// File: tb/flyback_pulse_timer_bench.sv
module flyback_pulse_timer_bench;
  localparam int ON_MAX  = 10;
  localparam int OFF_MAX = 12;
  localparam int MS      = 3;
  localparam int ML      = 6;
  localparam int RUN     = 4;
  localparam int WD_LIMIT = 20000;

  logic clk = 1'b0;
  logic rst_n, charge_en, ilim_flag, cond_end_flag, target_flag, short_window;
  logic gate_on, target_reached, fast_mode;

  int checks = 0, errors = 0, cyc = 0;
  int hi_run = 0, lo_run = 0, last_hi = 0, last_lo = 0;
  logic g_prev = 1'b0;

  always #10 clk = ~clk;

  flyback_pulse_timer #(
    .ON_MAX(ON_MAX), .OFF_MAX(OFF_MAX), .MINW_SHORT(MS),
    .MINW_LONG(ML), .FAST_RUN(RUN)
  ) u_flyback_pulse_timer (
    .clk(clk), .rst_n(rst_n), .charge_en(charge_en), .ilim_flag(ilim_flag),
    .cond_end_flag(cond_end_flag), .target_flag(target_flag),
    .short_window(short_window), .gate_on(gate_on),
    .target_reached(target_reached), .fast_mode(fast_mode)
  );

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  task automatic tick();
    @(negedge clk);
    cyc++;
    if (cyc > WD_LIMIT) begin
      checks++; errors++;
      $display("FAIL watchdog: got %0d cycles expected at most %0d", cyc, WD_LIMIT);
      finish_run();
    end
    if (gate_on && !g_prev) begin last_lo = lo_run; hi_run = 0; end
    if (!gate_on && g_prev) begin last_hi = hi_run; lo_run = 0; end
    if (gate_on) hi_run++; else lo_run++;
    g_prev = gate_on;
  endtask

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: got %0d expected %0d", req, act, exp);
    end
  endtask

  // on phase; current-limit flag driven on the k-th high sample (0 = never)
  task automatic on_phase(input int k);
    for (int n = 0; n < 200 && gate_on === 1'b1; n++) begin
      ilim_flag = (hi_run == k);
      tick();
    end
    ilim_flag = 1'b0;
  endtask

  // off phase; detect driven on the j-th low sample (0 = never)
  task automatic off_phase(input int j);
    for (int n = 0; n < 200 && gate_on === 1'b0; n++) begin
      cond_end_flag = (lo_run == j);
      tick();
    end
    cond_end_flag = 1'b0;
  endtask

  initial begin
    int bad;
    int seen_done;
    rst_n = 1'b0; charge_en = 1'b0; ilim_flag = 1'b0;
    cond_end_flag = 1'b0; target_flag = 1'b0; short_window = 1'b1;
    repeat (3) tick();
    rst_n = 1'b1;
    repeat (3) tick();
    chk("R1 reset gate", int'(gate_on), 0);
    chk("R1 reset done", int'(target_reached), 0);
    chk("R1 reset fast", int'(fast_mode), 0);

    charge_en = 1'b1;
    tick();
    chk("R1 start gate", int'(gate_on), 1);
    on_phase(0);
    chk("R3 on cap", last_hi, ON_MAX);
    off_phase(0);
    chk("R4 off timeout", last_lo, OFF_MAX);

    // timer mode: detects accepted but do not shorten; streak building
    for (int p = 1; p <= 7; p++) begin
      on_phase(p);
      chk("R2 trip width", last_hi, p);
      off_phase((p == 3) ? 2 : 5);
      chk("R6 timer off width", last_lo, OFF_MAX);
      chk("R7 mode flag", int'(fast_mode), (p == 7) ? 1 : 0);
    end

    // fast mode sweep over both windows and detect positions
    for (int s = 0; s < 2; s++) begin
      short_window = s[0];
      for (int j = 1; j < OFF_MAX; j++) begin
        int mw;
        mw = s ? MS : ML;
        on_phase(2);
        off_phase(j);
        chk((j >= mw) ? "R8 fast off width" : "R5 early detect ignored",
            last_lo, (j >= mw) ? j : OFF_MAX);
      end
    end

    // R9: target inside minimum window is ignored
    short_window = 1'b0;
    on_phase(2);
    seen_done = 0;
    for (int n = 0; n < 200 && gate_on === 1'b0; n++) begin
      target_flag = (lo_run == 3);
      tick();
      if (target_reached) seen_done = 1;
    end
    target_flag = 1'b0;
    chk("R9 early target ignored", last_lo, OFF_MAX);
    chk("R9 early target no pulse", seen_done, 0);

    // R9: target during on phase ignored
    target_flag = 1'b1;
    on_phase(3);
    target_flag = 1'b0;
    chk("R9 on target no pulse", int'(target_reached), 0);
    off_phase(7);
    chk("R9 charging continues", last_lo, 7);

    // R9: accepted target with simultaneous detect
    on_phase(2);
    while (lo_run < 7) tick();
    target_flag = 1'b1; cond_end_flag = 1'b1;
    tick();
    target_flag = 1'b0; cond_end_flag = 1'b0;
    chk("R9 done pulse", int'(target_reached), 1);
    chk("R9 gate low at done", int'(gate_on), 0);
    tick();
    chk("R9 pulse one cycle", int'(target_reached), 0);
    bad = 0;
    for (int n = 0; n < 3 * OFF_MAX; n++) begin
      cond_end_flag = n[0]; ilim_flag = n[1];
      tick();
      if (gate_on || target_reached) bad++;
    end
    cond_end_flag = 1'b0; ilim_flag = 1'b0;
    chk("R9 held off after done", bad, 0);

    // R10: disable and restart in timer mode
    charge_en = 1'b0;
    tick();
    chk("R10 gate off", int'(gate_on), 0);
    chk("R10 mode cleared", int'(fast_mode), 0);
    charge_en = 1'b1;
    tick();
    chk("R10 restart gate", int'(gate_on), 1);
    on_phase(0);
    chk("R3 on cap after restart", last_hi, ON_MAX);
    off_phase(7);
    chk("R6 timer mode after restart", last_lo, OFF_MAX);
    chk("R10 gate high before drop", int'(gate_on), 1);
    charge_en = 1'b0;
    tick();
    chk("R10 drop mid on phase", int'(gate_on), 0);

    finish_run();
  end
endmodule